// File: doc/BRIEF.md
# Programmable Periodic Down Timer

This block is a single countdown timer controlled through a small memory-mapped register port. Software writes one control word that carries an enable flag, a mode flag and a reload value of up to 28 bits. The counter then steps down once for each tick of a selected tick source. A tick source is a one-clock-wide qualifying pulse from outside the block, for example a microsecond strobe made by a prescaler elsewhere on the chip.

A tick that finds the count already at zero is an expiry. On an expiry the block drives a one-clock pulse on its expiry output and sets a sticky pending flag, which also drives the interrupt output. In periodic mode the counter reloads and keeps running, so a downstream consumer such as a watchdog sees a steady train of expirations. In one-shot mode the timer stops after the first expiry. Software clears the pending flag by writing a one to its bit in the status word.

Top module: `periodic_down_timer`

## Requirements
- R1: Control word at byte offset 0x0. Bit 31 is enable, bit 30 selects periodic mode (1) or one-shot (0), and bits 27:0 are the reload value. A read returns the stored mode and reload. Bit 31 reads the run flag, and bits 29:28 read 0.
- R2: A control write with bit 31 set loads the counter from the written reload value and starts the timer. While running, each tick of the selected source lowers the count by one. A tick that finds the count at 0 is an expiry. Reload N therefore expires on tick N+1, and reload 0 expires on the first tick.
- R3: For each expiry, `expiryOut` is high for exactly the one clock cycle after the edge that sampled the expiring tick.
- R4: In periodic mode the counter reloads on expiry and keeps running, which gives one expiry every N+1 ticks.
- R5: In one-shot mode the run flag clears on expiry. Control bit 31 then reads 0, and further ticks cause no expiry.
- R6: Status word at offset 0x4. Bit 30 is the pending flag. An expiry sets it, and it stays set until cleared. `irqOut` equals the pending flag. Writing 1 to bit 30 clears it, and writing 0 to bit 30 leaves it unchanged.
- R7: If an expiry and a clear write to status bit 30 fall in the same cycle, the pending flag stays set.
- R8: A control write with bit 31 clear stops the timer. No expiry follows until the timer is enabled again.
- R9: Source-select word at offset 0x8, low 4 bits. The value v selects `tickIn[v]`, and 0 selects `tickIn[0]`, the microsecond tick. A value of NUM_SRC or more selects no source, so the count does not move. A read returns the stored field.
- R10: A control write in the same cycle as a selected tick takes effect, and that tick is ignored.
- R11: After reset all three words read 0 and both outputs are low.
- R12: Reads of any other offset return 0, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset, used for both writes and reads |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for `regAddr` |
| tickIn | input | 4 | Candidate tick sources, one-clock pulses |
| expiryOut | output | 1 | One-clock pulse on each expiry |
| irqOut | output | 1 | Sticky pending interrupt |

## Verification
The bench builds the block with its defaults: a 28-bit counter, four tick sources and a 4-bit select field. Select values 4 to 15 therefore name no source, which lets the bench reach the case where the selected tick is unavailable. Reload values in the random phase are kept small, so periodic, one-shot and reload-0 expiries happen often. This also makes expiries collide with clear writes, control rewrites and select changes. The full 28-bit reload field is still exercised through readback.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 4;
  localparam int OFS_SRC  = 8;
  localparam int BIT_EN   = 31;
  localparam int BIT_PER  = 30;
  localparam int BIT_CLR  = 30;

  typedef struct packed {
    logic load;
    logic dec;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadValue,
  output logic             isZero
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= loadValue;
    end else if (strobe.dec) begin
      count <= count - 1'b1;
    end
  end

  assign isZero = (count == '0);

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> count == $past(loadValue));  // R2
  AST_DEC_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.load) |=> count == $past(count) - 1'b1);  // R2
  AST_DEC_NEVER_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |-> !isZero);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.dec && !strobe.load) |=> $stable(count));  // R9
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 28,
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_SRC-1:0] tickIn,
  input  logic              isZero,
  output tmrStrobe_t        strobe,
  output logic [CNT_W-1:0]  loadValue,
  output logic              expiryOut,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFS_SRC);

  logic             running;
  logic             periodic;
  logic [CNT_W-1:0] reloadReg;
  logic             pending;
  logic [SEL_W-1:0] srcSel;

  logic             wrCtrl;
  logic             wrStat;
  logic             wrSrc;
  logic             clrReq;
  logic             tickSel;
  logic             expire;
  logic [NUM_SRC-1:0] srcHit;

  assign wrCtrl = wrEn && (addr == A_CTRL);
  assign wrStat = wrEn && (addr == A_STAT);
  assign wrSrc  = wrEn && (addr == A_SRC);
  assign clrReq = wrStat && wdata[BIT_CLR];

  // one comparator per source; an out-of-range select matches none
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    assign srcHit[g] = tickIn[g] && (srcSel == SEL_W'(g));
  end
  assign tickSel = |srcHit;

  // a control write in the same cycle owns the counter
  assign expire     = running && tickSel && isZero && !wrCtrl;
  assign strobe.dec = running && tickSel && !isZero && !wrCtrl;
  assign strobe.load = (wrCtrl && wdata[BIT_EN]) || (expire && periodic);
  assign loadValue  = wrCtrl ? wdata[CNT_W-1:0] : reloadReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      periodic  <= 1'b0;
      reloadReg <= '0;
      srcSel    <= '0;
    end else begin
      if (wrCtrl) begin
        running   <= wdata[BIT_EN];
        periodic  <= wdata[BIT_PER];
        reloadReg <= wdata[CNT_W-1:0];
      end else if (expire && !periodic) begin
        running <= 1'b0;
      end
      if (wrSrc) begin
        srcSel <= wdata[SEL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      expiryOut <= 1'b0;
    end else begin
      expiryOut <= expire;
      if (expire) begin
        pending <= 1'b1;
      end else if (clrReq) begin
        pending <= 1'b0;
      end
    end
  end

  assign irqOut = pending;

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[BIT_EN]      = running;
        rdata[BIT_PER]     = periodic;
        rdata[CNT_W-1:0]   = reloadReg;
      end
      A_STAT: rdata[BIT_CLR] = pending;
      A_SRC:  rdata[SEL_W-1:0] = srcSel;
      default: rdata = '0;
    endcase
  end

  AST_PULSE_MEANS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    expiryOut |-> pending);  // R6
  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    expiryOut |-> $past(running));  // R3
  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !periodic) |=> !running);  // R5
  AST_PERIODIC_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (expire && periodic) |=> running);  // R4
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (expire && clrReq) |=> pending);  // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !expire) |=> !pending);  // R6
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !wdata[BIT_EN]) |=> (!running && !expiryOut));  // R8
  AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> !expiryOut);  // R10
endmodule

// File: rtl/periodic_down_timer.sv
module periodic_down_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 28,
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] tickIn,
  output logic               expiryOut,
  output logic               irqOut
);
  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] loadValue;
  logic             isZero;

  tmr_ctrl #(
    .CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrEn), .addr(regAddr), .wdata(regWdata), .rdata(regRdata),
    .tickIn(tickIn), .isZero(isZero),
    .strobe(strobe), .loadValue(loadValue),
    .expiryOut(expiryOut), .irqOut(irqOut)
  );

  tmr_datapath #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .loadValue(loadValue), .isZero(isZero)
  );
endmodule

// File: tb/periodic_down_timer_tb.sv
module periodic_down_timer_tb_top;
  localparam int CNT_W = 28;
  localparam int NUM_SRC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  tickIn = '0;
  logic        expiryOut;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic             mRun, mPer, mPend, mExp;
  logic [CNT_W-1:0] mReload, mCnt;
  logic [3:0]       mSel;

  always #2.5 clk = ~clk;

  periodic_down_timer dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tickIn(tickIn),
    .expiryOut(expiryOut), .irqOut(irqOut)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      4'h0: begin r[31] = mRun; r[30] = mPer; r[CNT_W-1:0] = mReload; end
      4'h4: r[30] = mPend;
      4'h8: r[3:0] = mSel;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic void modelReset();
    mRun = 0; mPer = 0; mPend = 0; mExp = 0; mReload = '0; mCnt = '0; mSel = '0;
  endfunction

  function automatic void modelStep(input logic wr, input logic [3:0] a,
                                    input logic [31:0] d, input logic [3:0] t);
    logic tk;
    tk = (mSel < NUM_SRC) ? t[mSel[1:0]] : 1'b0;
    mExp = 1'b0;
    if (wr && a == 4'h0) begin
      mReload = d[CNT_W-1:0]; mPer = d[30]; mRun = d[31];
      if (d[31]) mCnt = d[CNT_W-1:0];
    end else if (mRun && tk) begin
      if (mCnt == '0) begin
        mExp = 1'b1;
        if (mPer) mCnt = mReload; else mRun = 1'b0;
      end else begin
        mCnt = mCnt - 1'b1;
      end
    end
    if (mExp) mPend = 1'b1;
    else if (wr && a == 4'h4 && d[30]) mPend = 1'b0;
    if (wr && a == 4'h8) mSel = d[3:0];
  endfunction

  // one clock: drive, advance model, check outputs at the following negedge
  task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                     input logic [3:0] t, input string tag);
    regWrEn = wr; regAddr = a; regWdata = d; tickIn = t;
    modelStep(wr, a, d, t);
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; tickIn = '0;
    chk(expiryOut === mExp, tag, "expiryOut", 32'(expiryOut), 32'(mExp));
    chk(irqOut === mPend, "R6", "irqOut", 32'(irqOut), 32'(mPend));
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    regWrEn = 1'b0; regAddr = a; tickIn = '0;
    #0.5;
    chk(regRdata === modelRead(a), tag, "regRdata", regRdata, modelRead(a));
  endtask

  task automatic idle(input int n, input logic [3:0] t, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, '0, t, tag);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int nExp;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    chk(expiryOut === 1'b0, "R11", "expiryOut after reset", 32'(expiryOut), 0);
    chk(irqOut === 1'b0, "R11", "irqOut after reset", 32'(irqOut), 0);
    rd(4'h0, "R11"); rd(4'h4, "R11"); rd(4'h8, "R11");

    // R1 field readback with a wide reload, disabled
    cyc(1'b1, 4'h0, 32'h4ABC_DEF1, 4'h0, "R1");
    rd(4'h0, "R1");
    idle(3, 4'hF, "R8");

    // R2 reload 0 one-shot expires on first tick; R5 then stops
    cyc(1'b1, 4'h0, 32'h8000_0000, 4'h0, "R2");
    cyc(1'b0, 4'h0, '0, 4'h1, "R2");
    chk(expiryOut === 1'b1, "R2", "reload 0 first-tick expiry", 32'(expiryOut), 1);
    cyc(1'b0, 4'h0, '0, 4'h0, "R3");
    chk(expiryOut === 1'b0, "R3", "pulse one cycle", 32'(expiryOut), 0);
    rd(4'h0, "R5");
    idle(5, 4'h1, "R5");

    // R6 clear semantics
    cyc(1'b1, 4'h4, 32'hBFFF_FFFF, 4'h0, "R6");
    chk(irqOut === 1'b1, "R6", "write 0 to bit30 keeps pending", 32'(irqOut), 1);
    cyc(1'b1, 4'h4, 32'h4000_0000, 4'h0, "R6");
    chk(irqOut === 1'b0, "R6", "write 1 to bit30 clears", 32'(irqOut), 0);

    // R4 periodic reload 3: three expiries in twelve ticks
    cyc(1'b1, 4'h0, 32'hC000_0003, 4'h0, "R4");
    nExp = 0;
    for (int i = 0; i < 12; i++) begin
      cyc(1'b0, 4'h0, '0, 4'h1, "R4");
      if (expiryOut) nExp++;
    end
    chk(nExp == 3, "R4", "expiry count", 32'(nExp), 3);

    // R7 expiry collides with clear
    cyc(1'b1, 4'h0, 32'hC000_0000, 4'h0, "R7");
    cyc(1'b1, 4'h4, 32'h4000_0000, 4'h1, "R7");
    chk(irqOut === 1'b1, "R7", "set wins over clear", 32'(irqOut), 1);

    // R8 stop
    cyc(1'b1, 4'h0, 32'h4000_0000, 4'h1, "R8");
    idle(6, 4'hF, "R8");
    rd(4'h0, "R8");

    // R9 source select
    cyc(1'b1, 4'h8, 32'h0000_0002, 4'h0, "R9");
    rd(4'h8, "R9");
    cyc(1'b1, 4'h0, 32'h8000_0000, 4'h0, "R9");
    idle(3, 4'hB, "R9");
    cyc(1'b0, 4'h0, '0, 4'h4, "R9");
    chk(expiryOut === 1'b1, "R9", "tick on source 2", 32'(expiryOut), 1);
    cyc(1'b1, 4'h8, 32'h0000_0007, 4'h0, "R9");
    cyc(1'b1, 4'h0, 32'h8000_0000, 4'h0, "R9");
    idle(4, 4'hF, "R9");
    rd(4'h0, "R9");
    cyc(1'b1, 4'h8, 32'h0000_0000, 4'h0, "R9");

    // R10 control write with simultaneous tick
    cyc(1'b1, 4'h0, 32'h8000_0001, 4'h1, "R10");
    cyc(1'b0, 4'h0, '0, 4'h1, "R10");
    chk(expiryOut === 1'b0, "R10", "tick ignored during write", 32'(expiryOut), 0);
    cyc(1'b0, 4'h0, '0, 4'h1, "R10");
    chk(expiryOut === 1'b1, "R10", "expiry on second tick", 32'(expiryOut), 1);

    // R12 unmapped offsets
    cyc(1'b1, 4'hC, 32'hFFFF_FFFF, 4'h0, "R12");
    rd(4'hC, "R12"); rd(4'h0, "R12"); rd(4'h4, "R12"); rd(4'h8, "R12");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [3:0] t;
      r = $urandom_range(99);
      t = ($urandom_range(3) == 0) ? 4'h0 : 4'($urandom);
      if (r < 10)
        cyc(1'b1, 4'h0, {2'($urandom), 2'b00, 28'($urandom_range(7))}, t, "R2");
      else if (r < 15)
        cyc(1'b1, 4'h4, 32'($urandom), t, "R7");
      else if (r < 18)
        cyc(1'b1, 4'h8, 32'($urandom_range(5)), t, "R9");
      else if (r < 19)
        cyc(1'b1, 4'($urandom), 32'($urandom), t, "R12");
      else begin
        rd(4'($urandom), "R1");
        cyc(1'b0, regAddr, '0, t, "R3");
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule